// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps hours, minutes and seconds as six binary-coded decimal digits. Each digit is a small 4-bit counter limited to its own decimal range. The digits are linked in a chain: every stage passes a terminal-count signal forward, and that signal is the count enable of the next stage. A one-cycle-wide enable pulse, normally once per second, moves the time forward by one second.

The seconds and minutes fields each run from 00 to 59 and then return to 00. The hours field runs from 00 to 23 and then returns to 00. When the whole chain passes from 23:59:59 to 00:00:00, a rollover flag goes high for that enabled cycle. A day-count or date block can take this flag as its own enable.

The design has three layers. `tod_digit` is one truncated digit counter with a synchronous clear. `tod_field` joins two digits into one field. A package parameter selects whether the field wraps at 59 or at 23. The top module `tod_chain` connects the three fields. No control state machine is needed: the digit values are the only state. The block has only two conditions, counting and frozen, and the `en` input chooses between them in each cycle.

Top module: `tod_chain`

## Requirements
- R1: While `rst_n` is low, which acts asynchronously, all six digits read 0 and `rollover` is low.
- R2: A clock edge with `en` low leaves all six digits unchanged.
- R3: The seconds units digit advances by one on each edge with `en` high. After 9 it returns to 0.
- R4: The seconds tens digit advances only on an enabled edge where the units digit holds 9. The seconds field runs 00..59 and then 00.
- R5: The minutes field advances by one only on an enabled edge where the seconds field holds 59. Its sequence is 00..59 and then 00.
- R6: The hours field advances only on an enabled edge where minutes and seconds both hold 59. At 23 such an edge clears both hour digits to 0, even though the units digit is 3.
- R7: Below 20 hours, the hours units digit counts 0..9 and carries into the tens digit, so 09 becomes 10 and 19 becomes 20.
- R8: `rollover` is high exactly when `en` is high and the time reads 23:59:59. On the following edge the time becomes 00:00:00.
- R9: No digit ever leaves its range. The tens digits of seconds and minutes stay at 5 or below, the hours tens digit stays at 2 or below, and every units digit stays at 9 or below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable, one pulse per second |
| hr_tens | output | 4 | Hours, tens digit (BCD) |
| hr_units | output | 4 | Hours, units digit (BCD) |
| min_tens | output | 4 | Minutes, tens digit (BCD) |
| min_units | output | 4 | Minutes, units digit (BCD) |
| sec_tens | output | 4 | Seconds, tens digit (BCD) |
| sec_units | output | 4 | Seconds, units digit (BCD) |
| rollover | output | 1 | High for the enabled cycle at 23:59:59 |

## Verification
The bench runs more than a full day of seconds with the enable pattern broken by random idle cycles. This exercises the boundary edges of each field: 09→10 and 59→00 in seconds and minutes, 09→10, 19→20 and 23→00 in hours, and the complete day rollover. A design that wrapped the hours field at units 9 would show 24:00:00. A design that carried on units 9 alone would let the seconds or minutes tens digit reach 6. A design whose carry ignored the enable would move minutes during idle cycles. Each of these faults causes a mismatch with the bench's seconds-of-day model. An asynchronous reset applied in the middle of a clock cycle checks that all digits clear without waiting for an edge.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_t;

    // Selects the wrap point of a two-digit field.
    typedef enum logic {
        FIELD_BASE60 = 1'b0,
        FIELD_BASE24 = 1'b1
    } field_kind_e;
endpackage

// File: rtl/tod_digit.sv
module tod_digit
    import tod_pkg::*;
#(
    parameter int LAST = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic clr,
    output bcd_t q,
    output logic tc
);
    localparam bcd_t LAST_B = bcd_t'(LAST);

    bcd_t q_next;

    always_comb begin
        q_next = q;
        if (ce) begin
            if (clr || q == LAST_B) begin
                q_next = '0;
            end else begin
                q_next = q + bcd_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    assign tc = ce && (q == LAST_B);

    assert_digit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q <= LAST_B);

    assert_digit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q));
endmodule

// File: rtl/tod_field.sv
module tod_field
    import tod_pkg::*;
#(
    parameter field_kind_e KIND = FIELD_BASE60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    output bcd_t tens,
    output bcd_t units,
    output logic tc
);
    localparam int TENS_TOP  = (KIND == FIELD_BASE24) ? 2 : 5;
    localparam int UNITS_TOP = (KIND == FIELD_BASE24) ? 3 : 9;

    logic at_top;
    logic units_tc;
    logic tens_ce;
    logic tens_tc;

    assign at_top = (tens == bcd_t'(TENS_TOP)) && (units == bcd_t'(UNITS_TOP));

    tod_digit #(.LAST(9)) u_units (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (ce),
        .clr  (at_top),
        .q    (units),
        .tc   (units_tc)
    );

    assign tens_ce = units_tc || (ce && at_top);

    tod_digit #(.LAST(TENS_TOP)) u_tens (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (tens_ce),
        .clr  (at_top),
        .q    (tens),
        .tc   (tens_tc)
    );

    assign tc = ce && at_top;

    // At the field's top value, the tens digit also holds its own limit.
    assert_field_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> tens_tc);

    assert_field_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (tens == '0 && units == '0));
endmodule

// File: rtl/tod_chain.sv
module tod_chain
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_units,
    output logic [3:0] min_tens,
    output logic [3:0] min_units,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_units,
    output logic       rollover
);
    logic sec_tc;
    logic min_tc;
    logic hr_tc;

    tod_field #(.KIND(FIELD_BASE60)) u_sec (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (en),
        .tens (sec_tens),
        .units(sec_units),
        .tc   (sec_tc)
    );

    tod_field #(.KIND(FIELD_BASE60)) u_min (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (sec_tc),
        .tens (min_tens),
        .units(min_units),
        .tc   (min_tc)
    );

    tod_field #(.KIND(FIELD_BASE24)) u_hr (
        .clk  (clk),
        .rst_n(rst_n),
        .ce   (min_tc),
        .tens (hr_tens),
        .units(hr_units),
        .tc   (hr_tc)
    );

    assign rollover = hr_tc;

    assert_min_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tc |=> $stable({min_tens, min_units}));

    assert_hr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !min_tc |=> $stable({hr_tens, hr_units}));

    assert_rollover_when_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |-> (en && hr_tens == 4'd2 && hr_units == 4'd3 &&
                      min_tens == 4'd5 && min_units == 4'd9 &&
                      sec_tens == 4'd5 && sec_units == 4'd9));

    assert_rollover_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> ({hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units} == 24'h0));

    assert_hr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hr_tens <= 4'd2 && !(hr_tens == 4'd2 && hr_units > 4'd3));
endmodule

// File: tb/tod_chain_test.sv
module tod_chain_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;
    logic       rollover;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int tsec = 0;
    logic last_en = 1'b0;
    logic prev_valid = 1'b0;
    logic [23:0] prev_digits = '0;
    int rollovers_seen = 0;

    always #5 clk = ~clk;

    tod_chain uut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .hr_tens(hr_tens), .hr_units(hr_units),
        .min_tens(min_tens), .min_units(min_units),
        .sec_tens(sec_tens), .sec_units(sec_units),
        .rollover(rollover)
    );

    // Behavioural reference: seconds since midnight.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsec    <= 0;
            last_en <= 1'b0;
        end else begin
            last_en <= en;
            if (en) tsec <= (tsec + 1) % 86400;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below 190000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check_val(input string tag, input int act, input int exp);
        compared = compared + 1;
        if (act != exp) begin
            mismatched = mismatched + 1;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0d)", tag, act, exp, tsec);
        end
    endtask

    task automatic compare_all();
        int h, m, s;
        logic [23:0] now;
        h = tsec / 3600;
        m = (tsec / 60) % 60;
        s = tsec % 60;
        now = {hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};
        check_val("R3 sec_units", int'(sec_units), s % 10);
        check_val("R4 sec_tens", int'(sec_tens), s / 10);
        check_val("R5 min_units", int'(min_units), m % 10);
        check_val("R5 min_tens", int'(min_tens), m / 10);
        check_val("R7 hr_units", int'(hr_units), h % 10);
        check_val("R6 hr_tens", int'(hr_tens), h / 10);
        check_val("R8 rollover", int'(rollover), (en && tsec == 86399) ? 1 : 0);
        if (rollover) rollovers_seen = rollovers_seen + 1;
        // R9: range limits
        check_val("R9 range", (sec_tens <= 4'd5 && min_tens <= 4'd5 && hr_tens <= 4'd2 &&
                               sec_units <= 4'd9 && min_units <= 4'd9 && hr_units <= 4'd9) ? 1 : 0, 1);
        // R2: idle edge leaves digits untouched
        if (prev_valid && !last_en) check_val("R2 freeze", int'(now == prev_digits), 1);
        prev_digits = now;
        prev_valid  = 1'b1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_val("R1 reset digits", int'({hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units}), 0);
        check_val("R1 reset rollover", int'(rollover), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 100000; i++) begin
            @(negedge clk);
            compare_all();
            en = ($urandom_range(0, 9) != 0);
        end

        // R1: asynchronous reset in mid-cycle
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1;
        check_val("R1 async clear", int'({hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units}), 0);
        prev_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b1;

        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            compare_all();
        end

        check_val("R8 rollover observed", rollovers_seen >= 1 ? 1 : 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule